// File: doc/BRIEF.md
# Test Port Instruction Decoder and Control

This block sits behind the state machine of a four-wire boundary-scan test port. It holds the instruction register, made of a shift stage and an active copy. It decodes the instruction that is active and drives the control signals that follow from it. Those signals choose the data register placed between the serial input and the serial output: either a one-bit bypass cell or the external boundary chain. They also gate the capture, shift and update strobes of the boundary chain. They tell the pad ring whether to float every output, or to drive every output from the values held in the boundary chain. They ask the chip to hold its system logic in reset.

The state machine outside the block supplies one flag for each state of interest. Each flag is high during the test-clock cycle spent in that state. The block runs on the test clock. All pad and reset controls are registered, and they move only when Update-IR takes a new instruction or when the test logic is reset. A test that only shifts bits therefore never disturbs the pads or the system. Two instructions force the pads and reset the system while the serial path stays one bit long, so the scan chain through the board remains short.

Top module: `jtdec_ctrl`

## Requirements
- R1: A synchronous `rst`, or a clock edge with `st_tlr` high, makes the active instruction 4'b1111 with `sel_bsr`, `pad_hiz`, `pad_drive_bsr` and `sys_rst_req` all 0; `st_tlr` wins over `st_update_ir` in the same cycle.
- R2: A Capture-IR edge loads 4'b0001 into the instruction shift stage; each Shift-IR edge moves `tdi` into the most significant bit, and `tdo` shows bit 0, so the bits leave least significant first.
- R3: At an Update-IR edge the shifted value becomes `ir_active`, and the controls decoded from it appear on the outputs after that same edge.
- R4: Code 4'b0000 (external test) selects the boundary chain and sets `pad_drive_bsr`, with `pad_hiz` and `sys_rst_req` at 0.
- R5: Code 4'b0001 (sample/preload) selects the boundary chain, with no pad override and no reset request.
- R6: Code 4'b0010 (float pads) selects the bypass cell and sets both `pad_hiz` and `sys_rst_req`, with `pad_drive_bsr` at 0.
- R7: Code 4'b0011 (clamp) selects the bypass cell and sets both `pad_drive_bsr` and `sys_rst_req`, with `pad_hiz` at 0.
- R8: Code 4'b1111 and every code not listed above select the bypass cell with all pad and reset controls at 0.
- R9: When the bypass cell is selected, it captures 0 in Capture-DR; during Shift-DR `tdo` shows the cell, so each `tdi` bit reaches `tdo` one clock later.
- R10: When the boundary chain is selected, `tdo` follows `bsr_so` during Shift-DR, and `bsr_capture`, `bsr_shift` and `bsr_update` follow the matching DR state flags; when the bypass cell is selected, all three strobes stay 0.
- R11: Capture-IR, Shift-IR and all DR states leave `ir_active`, `sel_bsr`, `pad_hiz`, `pad_drive_bsr` and `sys_rst_req` unchanged.
- R12: `tdo_en` is 1 exactly while `st_shift_ir` or `st_shift_dr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| st_tlr | input | 1 | State machine is in Test-Logic-Reset |
| st_capture_ir | input | 1 | State machine is in Capture-IR |
| st_shift_ir | input | 1 | State machine is in Shift-IR |
| st_update_ir | input | 1 | State machine is in Update-IR |
| st_capture_dr | input | 1 | State machine is in Capture-DR |
| st_shift_dr | input | 1 | State machine is in Shift-DR |
| st_update_dr | input | 1 | State machine is in Update-DR |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Serial output of the boundary chain |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Output enable for the serial output |
| ir_active | output | IR_W | Instruction currently in effect |
| sel_bsr | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Capture strobe to the boundary chain |
| bsr_shift | output | 1 | Shift strobe to the boundary chain |
| bsr_update | output | 1 | Update strobe to the boundary chain |
| pad_hiz | output | 1 | Put every pad output into high impedance |
| pad_drive_bsr | output | 1 | Drive pads from the boundary chain's held values |
| sys_rst_req | output | 1 | Hold the system logic in reset |

## Verification
Each of the five defined codes is shifted in, along with four undefined codes (0100, 0111, 1010, 1110). This separates the two data paths, and it separates the two instructions that keep the bypass path but force the pads from plain bypass. A new code is shifted but not updated, and then full DR scans are run, to show that the controls move only on Update-IR. Test-logic reset arriving in the same cycle as Update-IR shows which of the two wins. In the data path, an alternating `tdi` pattern through the bypass cell separates the captured zero from a path that only passes bits through. A changing `bsr_so` under the boundary chain shows which source drives `tdo`.

// File: rtl/jtdec_pkg.sv
package jtdec_pkg;

  // Decoded controls held while an instruction is in effect
  typedef struct packed {
    logic sel_bsr;
    logic pad_hiz;
    logic pad_drive;
    logic sys_rst;
  } jtdec_ctrl_t;

  localparam jtdec_ctrl_t JTDEC_CTRL_IDLE = '{sel_bsr: 1'b0, pad_hiz: 1'b0,
                                             pad_drive: 1'b0, sys_rst: 1'b0};

endpackage

// File: rtl/jtdec_ir.sv
module jtdec_ir #(
  parameter int unsigned IR_W = 4,
  parameter logic [IR_W-1:0] CAPTURE_VAL = 'b1,
  localparam logic [IR_W-1:0] IDLE_CODE = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_tlr,
  input  logic            cap_en,
  input  logic            shift_en,
  input  logic            upd_en,
  input  logic            tdi,
  output logic [IR_W-1:0] shift_q,
  output logic [IR_W-1:0] active_q,
  output logic            so
);

  // Shift stage: capture pattern, then LSB-first serial shift
  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= CAPTURE_VAL;
    end else if (cap_en) begin
      shift_q <= CAPTURE_VAL;
    end else if (shift_en) begin
      shift_q <= {tdi, shift_q[IR_W-1:1]};
    end
  end

  // Active copy: test-logic reset wins over update
  always_ff @(posedge clk) begin
    if (rst || st_tlr) begin
      active_q <= IDLE_CODE;
    end else if (upd_en) begin
      active_q <= shift_q;
    end
  end

  assign so = shift_q[0];

endmodule

// File: rtl/jtdec_decode.sv
module jtdec_decode
  import jtdec_pkg::*;
#(
  parameter int unsigned IR_W = 4,
  parameter logic [IR_W-1:0] OP_EXTEST = 'd0,
  parameter logic [IR_W-1:0] OP_SAMPLE = 'd1,
  parameter logic [IR_W-1:0] OP_HIGHZ  = 'd2,
  parameter logic [IR_W-1:0] OP_CLAMP  = 'd3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_tlr,
  input  logic            upd_en,
  input  logic [IR_W-1:0] ir_next,
  output jtdec_ctrl_t     ctrl_q
);

  jtdec_ctrl_t ctrl_d;

  // Unlisted codes, including all-ones, fall back to bypass behaviour
  always_comb begin
    ctrl_d = JTDEC_CTRL_IDLE;
    if (ir_next == OP_EXTEST) begin
      ctrl_d.sel_bsr   = 1'b1;
      ctrl_d.pad_drive = 1'b1;
    end else if (ir_next == OP_SAMPLE) begin
      ctrl_d.sel_bsr   = 1'b1;
    end else if (ir_next == OP_HIGHZ) begin
      ctrl_d.pad_hiz   = 1'b1;
      ctrl_d.sys_rst   = 1'b1;
    end else if (ir_next == OP_CLAMP) begin
      ctrl_d.pad_drive = 1'b1;
      ctrl_d.sys_rst   = 1'b1;
    end
  end

  // Registered so pad and reset controls move only on update or reset
  always_ff @(posedge clk) begin
    if (rst || st_tlr) begin
      ctrl_q <= JTDEC_CTRL_IDLE;
    end else if (upd_en) begin
      ctrl_q <= ctrl_d;
    end
  end

endmodule

// File: rtl/jtdec_bypass.sv
module jtdec_bypass (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_en,
  input  logic tdi,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (cap_en) begin
      q <= 1'b0;
    end else if (shift_en) begin
      q <= tdi;
    end
  end

endmodule

// File: rtl/jtdec_ctrl.sv
module jtdec_ctrl
  import jtdec_pkg::*;
#(
  parameter int unsigned IR_W = 4,
  parameter logic [IR_W-1:0] IR_CAPTURE = 'b1,
  parameter logic [IR_W-1:0] OP_EXTEST  = 'd0,
  parameter logic [IR_W-1:0] OP_SAMPLE  = 'd1,
  parameter logic [IR_W-1:0] OP_HIGHZ   = 'd2,
  parameter logic [IR_W-1:0] OP_CLAMP   = 'd3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_tlr,
  input  logic            st_capture_ir,
  input  logic            st_shift_ir,
  input  logic            st_update_ir,
  input  logic            st_capture_dr,
  input  logic            st_shift_dr,
  input  logic            st_update_dr,
  input  logic            tdi,
  input  logic            bsr_so,
  output logic            tdo,
  output logic            tdo_en,
  output logic [IR_W-1:0] ir_active,
  output logic            sel_bsr,
  output logic            bsr_capture,
  output logic            bsr_shift,
  output logic            bsr_update,
  output logic            pad_hiz,
  output logic            pad_drive_bsr,
  output logic            sys_rst_req
);

  logic [IR_W-1:0] ir_shift;
  logic            ir_so;
  logic            byp_q;
  jtdec_ctrl_t     ctrl_q;

  jtdec_ir #(
    .IR_W        (IR_W),
    .CAPTURE_VAL (IR_CAPTURE)
  ) u_ir (
    .clk      (clk),
    .rst      (rst),
    .st_tlr   (st_tlr),
    .cap_en   (st_capture_ir),
    .shift_en (st_shift_ir),
    .upd_en   (st_update_ir),
    .tdi      (tdi),
    .shift_q  (ir_shift),
    .active_q (ir_active),
    .so       (ir_so)
  );

  jtdec_decode #(
    .IR_W      (IR_W),
    .OP_EXTEST (OP_EXTEST),
    .OP_SAMPLE (OP_SAMPLE),
    .OP_HIGHZ  (OP_HIGHZ),
    .OP_CLAMP  (OP_CLAMP)
  ) u_dec (
    .clk     (clk),
    .rst     (rst),
    .st_tlr  (st_tlr),
    .upd_en  (st_update_ir),
    .ir_next (ir_shift),
    .ctrl_q  (ctrl_q)
  );

  jtdec_bypass u_byp (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (st_capture_dr && !ctrl_q.sel_bsr),
    .shift_en (st_shift_dr && !ctrl_q.sel_bsr),
    .tdi      (tdi),
    .q        (byp_q)
  );

  assign sel_bsr       = ctrl_q.sel_bsr;
  assign pad_hiz       = ctrl_q.pad_hiz;
  assign pad_drive_bsr = ctrl_q.pad_drive;
  assign sys_rst_req   = ctrl_q.sys_rst;

  assign bsr_capture = st_capture_dr && ctrl_q.sel_bsr;
  assign bsr_shift   = st_shift_dr   && ctrl_q.sel_bsr;
  assign bsr_update  = st_update_dr  && ctrl_q.sel_bsr;

  // Serial output source
  always_comb begin
    tdo = 1'b0;
    if (st_shift_ir) begin
      tdo = ir_so;
    end else if (st_shift_dr) begin
      tdo = ctrl_q.sel_bsr ? bsr_so : byp_q;
    end
  end

  assign tdo_en = st_shift_ir || st_shift_dr;

endmodule

// File: rtl/jtdec_ctrl_chk.sv
module jtdec_ctrl_chk #(
  parameter int unsigned IR_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            st_tlr,
  input logic            st_update_ir,
  input logic            st_capture_dr,
  input logic            st_shift_dr,
  input logic            tdo,
  input logic [IR_W-1:0] ir_active,
  input logic [IR_W-1:0] ir_shift,
  input logic            sel_bsr,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update,
  input logic            pad_hiz,
  input logic            pad_drive_bsr,
  input logic            sys_rst_req
);

  AST_TLR_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    st_tlr |=> (ir_active == '1 && !sel_bsr && !pad_hiz && !pad_drive_bsr && !sys_rst_req)); // R1

  AST_UPDATE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (st_update_ir && !st_tlr) |=> (ir_active == $past(ir_shift))); // R3

  AST_HIZ_WITH_RESET: assert property (@(posedge clk) disable iff (rst)
    pad_hiz |-> (sys_rst_req && !sel_bsr && !pad_drive_bsr)); // R6

  AST_CLAMP_SHORT_PATH: assert property (@(posedge clk) disable iff (rst)
    (pad_drive_bsr && !sel_bsr) |-> sys_rst_req); // R7

  AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge clk) disable iff (rst)
    (st_capture_dr && !sel_bsr) ##1 st_shift_dr |-> !tdo); // R9

  AST_STROBES_GATED: assert property (@(posedge clk) disable iff (rst)
    (bsr_capture || bsr_shift || bsr_update) |-> sel_bsr); // R10

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!st_update_ir && !st_tlr) |=>
      $stable({ir_active, sel_bsr, pad_hiz, pad_drive_bsr, sys_rst_req})); // R11

endmodule

bind jtdec_ctrl jtdec_ctrl_chk #(.IR_W(IR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .st_tlr        (st_tlr),
  .st_update_ir  (st_update_ir),
  .st_capture_dr (st_capture_dr),
  .st_shift_dr   (st_shift_dr),
  .tdo           (tdo),
  .ir_active     (ir_active),
  .ir_shift      (ir_shift),
  .sel_bsr       (sel_bsr),
  .bsr_capture   (bsr_capture),
  .bsr_shift     (bsr_shift),
  .bsr_update    (bsr_update),
  .pad_hiz       (pad_hiz),
  .pad_drive_bsr (pad_drive_bsr),
  .sys_rst_req   (sys_rst_req)
);

// File: tb/jtdec_ctrl_bench.sv
`timescale 1ns/1ps
module jtdec_ctrl_bench;
  localparam int IR_W = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, st_tlr, st_capture_ir, st_shift_ir, st_update_ir;
  logic st_capture_dr, st_shift_dr, st_update_dr, tdi, bsr_so;
  logic tdo, tdo_en, sel_bsr, bsr_capture, bsr_shift, bsr_update;
  logic pad_hiz, pad_drive_bsr, sys_rst_req;
  logic [IR_W-1:0] ir_active;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  jtdec_ctrl u_jtdec_ctrl (
    .clk(clk), .rst(rst), .st_tlr(st_tlr), .st_capture_ir(st_capture_ir),
    .st_shift_ir(st_shift_ir), .st_update_ir(st_update_ir),
    .st_capture_dr(st_capture_dr), .st_shift_dr(st_shift_dr),
    .st_update_dr(st_update_dr), .tdi(tdi), .bsr_so(bsr_so), .tdo(tdo),
    .tdo_en(tdo_en), .ir_active(ir_active), .sel_bsr(sel_bsr),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .pad_hiz(pad_hiz), .pad_drive_bsr(pad_drive_bsr), .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    st_tlr = 0; st_capture_ir = 0; st_shift_ir = 0; st_update_ir = 0;
    st_capture_dr = 0; st_shift_dr = 0; st_update_dr = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_ctrl(input string req, input logic [3:0] code,
                          input logic s, input logic h, input logic d, input logic r);
    chk(req, "ir_active", ir_active, code);
    chk(req, "sel_bsr", sel_bsr, s);
    chk(req, "pad_hiz", pad_hiz, h);
    chk(req, "pad_drive_bsr", pad_drive_bsr, d);
    chk(req, "sys_rst_req", sys_rst_req, r);
  endtask

  // Capture and shift a code; optionally update
  task automatic shift_ir(input logic [3:0] code, input bit do_update,
                          output logic [3:0] outbits);
    idle();
    st_capture_ir = 1; step();
    st_capture_ir = 0; st_shift_ir = 1;
    for (int i = 0; i < IR_W; i++) begin
      tdi = code[i]; #1;
      outbits[i] = tdo;
      step();
    end
    st_shift_ir = 0;
    if (do_update) begin
      st_update_ir = 1; step(); st_update_ir = 0;
    end
  endtask

  task automatic t_reset();
    rst = 1; idle(); tdi = 0; bsr_so = 0;
    step(); step();
    rst = 0; step();
    chk_ctrl("R1", 4'hF, 0, 0, 0, 0);
  endtask

  task automatic t_modes();
    logic [3:0] ob;
    shift_ir(4'b0000, 1, ob);
    chk("R2", "ir capture out", ob, 4'b0001);
    chk_ctrl("R4", 4'b0000, 1, 0, 1, 0);
    shift_ir(4'b0001, 1, ob);
    chk_ctrl("R5", 4'b0001, 1, 0, 0, 0);
    shift_ir(4'b0010, 1, ob);
    chk_ctrl("R6", 4'b0010, 0, 1, 0, 1);
    shift_ir(4'b0011, 1, ob);
    chk_ctrl("R7", 4'b0011, 0, 0, 1, 1);
    shift_ir(4'b1111, 1, ob);
    chk_ctrl("R8", 4'b1111, 0, 0, 0, 0);
    foreach (ob[k]) ;
    begin
      logic [3:0] others [4] = '{4'b0100, 4'b0111, 4'b1010, 4'b1110};
      for (int j = 0; j < 4; j++) begin
        shift_ir(others[j], 1, ob);
        chk("R2", "ir capture out", ob, 4'b0001);
        chk_ctrl("R8", others[j], 0, 0, 0, 0);
      end
    end
  endtask

  task automatic t_hold();
    logic [3:0] ob;
    shift_ir(4'b0000, 1, ob);
    shift_ir(4'b0010, 0, ob);
    chk_ctrl("R11", 4'b0000, 1, 0, 1, 0);
    st_capture_dr = 1; step(); st_capture_dr = 0;
    st_shift_dr = 1; tdi = 1; step(); step(); st_shift_dr = 0;
    st_update_dr = 1; step(); st_update_dr = 0;
    chk_ctrl("R11", 4'b0000, 1, 0, 1, 0);
    st_update_ir = 1; step(); st_update_ir = 0;
    chk_ctrl("R3", 4'b0010, 0, 1, 0, 1);
  endtask

  task automatic t_bypass_dr();
    logic [3:0] ob;
    logic [5:0] pat = 6'b101101;
    logic prev;
    shift_ir(4'b1111, 1, ob);
    tdi = 1;
    st_capture_dr = 1; #1;
    chk("R10", "bsr_capture gated", bsr_capture, 0);
    step(); st_capture_dr = 0;
    st_shift_dr = 1; prev = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tdi = pat[i]; bsr_so = ~prev; #1;
      chk("R9", "bypass tdo", tdo, prev);
      chk("R10", "bsr_shift gated", bsr_shift, 0);
      prev = pat[i];
      step();
    end
    st_shift_dr = 0;
    st_update_dr = 1; #1;
    chk("R10", "bsr_update gated", bsr_update, 0);
    step(); st_update_dr = 0;
  endtask

  task automatic t_bsr_dr();
    logic [3:0] ob;
    logic [3:0] so_pat = 4'b0110;
    shift_ir(4'b0001, 1, ob);
    st_capture_dr = 1; #1;
    chk("R10", "bsr_capture", bsr_capture, 1);
    step(); st_capture_dr = 0;
    st_shift_dr = 1; tdi = 0;
    for (int i = 0; i < 4; i++) begin
      bsr_so = so_pat[i]; #1;
      chk("R10", "tdo follows bsr_so", tdo, so_pat[i]);
      chk("R10", "bsr_shift", bsr_shift, 1);
      step();
    end
    st_shift_dr = 0;
    st_update_dr = 1; #1;
    chk("R10", "bsr_update", bsr_update, 1);
    step(); st_update_dr = 0;
  endtask

  task automatic t_tdo_en();
    idle(); #1;
    chk("R12", "tdo_en idle", tdo_en, 0);
    st_capture_dr = 1; #1;
    chk("R12", "tdo_en capture", tdo_en, 0);
    st_capture_dr = 0; st_shift_ir = 1; #1;
    chk("R12", "tdo_en shift_ir", tdo_en, 1);
    st_shift_ir = 0; st_shift_dr = 1; #1;
    chk("R12", "tdo_en shift_dr", tdo_en, 1);
    st_shift_dr = 0; #1;
  endtask

  task automatic t_tlr();
    logic [3:0] ob;
    shift_ir(4'b0010, 1, ob);
    chk_ctrl("R6", 4'b0010, 0, 1, 0, 1);
    st_tlr = 1; step(); st_tlr = 0;
    chk_ctrl("R1", 4'hF, 0, 0, 0, 0);
    shift_ir(4'b0011, 0, ob);
    st_update_ir = 1; st_tlr = 1; step(); idle();
    chk_ctrl("R1", 4'hF, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_modes();
    t_hold();
    t_bypass_dr();
    t_bsr_dr();
    t_tdo_en();
    t_tlr();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule